// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a fully associative translation cache with 64 entries. Each entry holds a tag word and a translation word. Each entry carries its own page size, so every comparison uses that entry's own address mask. Page sizes run from an 8 KB base page up to 4 MB.

A lookup port takes a virtual address, a 13-bit context and an access type (instruction or data). It answers combinationally with hit, the matching slot, the matching translation word and the granted permissions. On the following clock edge it marks the matching entry as used, which feeds an external replacement policy.

A demap port invalidates, in one cycle, every valid entry whose page covers the given address; it does not look at the context. A write port loads a tag and a translation word into the slot named by address bits 8:3.

Top module: `tlb_vpage`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: A lookup hits an entry only when all three conditions hold: translation bit 63 (valid) is set, the tag's low 13 bits equal the request context, and the address equals the tag under that entry's page mask.
- R3: The page mask clears the low 13 address bits and then shifts left by 3 times the size code in translation bits 62:61. Codes 0..3 give pages of 8 KB, 64 KB, 512 KB and 4 MB. An address one byte past the page misses.
- R4: A data hit grants read. It grants write only when translation bit 1 is set. It never grants execute.
- R5: An instruction hit grants execute and neither read nor write.
- R6: A lookup hit sets translation bit 41 (used) of the matching entry on the next clock edge. The word returned on a later hit shows that bit.
- R7: A miss drives hit, all permissions and the returned word to zero, and changes no used flag.
- R8: When several entries match a lookup, the lowest slot index is reported.
- R9: A demap invalidates every valid entry whose tag equals the demap address under that entry's own page mask, ignoring context. Entries whose page does not cover the address stay valid.
- R10: A demap in the same cycle as a lookup forces the lookup to miss, and the used flags stay unchanged.
- R11: A write loads both words into the slot given by write address bits 8:3 on the next edge. The written word replaces the whole entry, including its used flag.
- R12: A write and a demap in the same cycle leave the written entry exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_va_i | input | 64 | Lookup virtual address |
| lkp_ctx_i | input | 13 | Lookup context |
| lkp_is_instr_i | input | 1 | 1 = instruction access, 0 = data access |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_idx_o | output | 6 | Slot of the hit entry |
| lkp_tte_o | output | 64 | Translation word of the hit entry, zero on miss |
| lkp_read_o | output | 1 | Read granted |
| lkp_write_o | output | 1 | Write granted |
| lkp_exec_o | output | 1 | Execute granted |
| dmp_valid_i | input | 1 | Demap request |
| dmp_va_i | input | 64 | Demap address |
| wr_valid_i | input | 1 | Entry write request |
| wr_addr_i | input | 6 | Write address bits 8:3, selecting the slot |
| wr_tag_i | input | 64 | Tag word to load (context in bits 12:0) |
| wr_tte_i | input | 64 | Translation word to load |

## Verification
The assertions assume that lookup inputs are held stable across the clock edge that applies the used-flag update. They also assume that a write never targets the slot a lookup hits in the same cycle, unless that case is excluded by the property itself. The bench drives all inputs at the falling edge and holds them through the next rising edge. It gives every entry its own 4 GB region, so unintended overlaps cannot occur. Overlap is created only where the lowest-slot and demap-all cases need it.

// File: rtl/tlb_vpage_pkg.sv
package tlb_vpage_pkg;
  localparam int unsigned VA_W        = 64;
  localparam int unsigned TTE_W       = 64;
  localparam int unsigned CTX_W       = 13;
  localparam int unsigned BASE_PAGE_W = 13;
  localparam int unsigned SIZE_STEP   = 3;
  localparam int unsigned VALID_BIT   = 63;
  localparam int unsigned SZ_HI       = 62;
  localparam int unsigned SZ_LO       = 61;
  localparam int unsigned USED_BIT    = 41;
  localparam int unsigned WRITE_BIT   = 1;

  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    return {VA_W{1'b1}} << (BASE_PAGE_W + SIZE_STEP * 32'(sz));
  endfunction
endpackage

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
  import tlb_vpage_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64
) (
  input  logic [NUM_ENTRIES-1:0][VA_W-1:0]  tag_i,
  input  logic [NUM_ENTRIES-1:0][TTE_W-1:0] tte_i,
  input  logic [VA_W-1:0]                   lkp_va_i,
  input  logic [CTX_W-1:0]                  lkp_ctx_i,
  input  logic [VA_W-1:0]                   dmp_va_i,
  output logic [NUM_ENTRIES-1:0]            lkp_match_o,
  output logic [NUM_ENTRIES-1:0]            dmp_match_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [VA_W-1:0] msk;
    logic            vld;
    logic            ctx_eq;
    assign msk    = page_mask(tte_i[g][SZ_HI:SZ_LO]);
    assign vld    = tte_i[g][VALID_BIT];
    assign ctx_eq = (tag_i[g][CTX_W-1:0] == lkp_ctx_i);
    assign lkp_match_o[g] = vld && ctx_eq && (((lkp_va_i ^ tag_i[g]) & msk) == '0);
    // context is not part of a demap compare
    assign dmp_match_o[g] = vld && (((dmp_va_i ^ tag_i[g]) & msk) == '0);
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] req_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o
);
  // scan downward so the lowest set request is the last assignment
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_vpage_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [VA_W-1:0]                   wr_tag_i,
  input  logic [TTE_W-1:0]                  wr_tte_i,
  input  logic [NUM_ENTRIES-1:0]            kill_i,
  input  logic [NUM_ENTRIES-1:0]            used_set_i,
  output logic [NUM_ENTRIES-1:0][VA_W-1:0]  tag_o,
  output logic [NUM_ENTRIES-1:0][TTE_W-1:0] tte_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [VA_W-1:0]  tag_q;
    logic [TTE_W-1:0] tte_q;
    logic [TTE_W-1:0] tte_upd;
    logic             sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_comb begin
      tte_upd = tte_q;
      if (kill_i[g])     tte_upd[VALID_BIT] = 1'b0;
      if (used_set_i[g]) tte_upd[USED_BIT]  = 1'b1;
    end

    // a write overrides demap and used marking on its slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        tte_q <= '0;
      end else if (sel) begin
        tag_q <= wr_tag_i;
        tte_q <= wr_tte_i;
      end else begin
        tte_q <= tte_upd;
      end
    end

    assign tag_o[g] = tag_q;
    assign tte_o[g] = tte_q;
  end
endmodule

// File: rtl/tlb_vpage.sv
module tlb_vpage
  import tlb_vpage_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned IDX_LSB     = 3,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         lkp_valid_i,
  input  logic [VA_W-1:0]              lkp_va_i,
  input  logic [CTX_W-1:0]             lkp_ctx_i,
  input  logic                         lkp_is_instr_i,
  output logic                         lkp_hit_o,
  output logic [IDX_W-1:0]             lkp_idx_o,
  output logic [TTE_W-1:0]             lkp_tte_o,
  output logic                         lkp_read_o,
  output logic                         lkp_write_o,
  output logic                         lkp_exec_o,
  input  logic                         dmp_valid_i,
  input  logic [VA_W-1:0]              dmp_va_i,
  input  logic                         wr_valid_i,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB] wr_addr_i,
  input  logic [VA_W-1:0]              wr_tag_i,
  input  logic [TTE_W-1:0]             wr_tte_i
);
  logic [NUM_ENTRIES-1:0][VA_W-1:0]  tag_q;
  logic [NUM_ENTRIES-1:0][TTE_W-1:0] tte_q;
  logic [NUM_ENTRIES-1:0]            lkp_match;
  logic [NUM_ENTRIES-1:0]            dmp_match;
  logic [NUM_ENTRIES-1:0]            kill;
  logic [NUM_ENTRIES-1:0]            used_set;
  logic                              found;
  logic [IDX_W-1:0]                  found_idx;
  logic [IDX_W-1:0]                  wr_idx;
  logic [TTE_W-1:0]                  hit_tte;

  tlb_match_unit #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .tag_i       (tag_q),
    .tte_i       (tte_q),
    .lkp_va_i    (lkp_va_i),
    .lkp_ctx_i   (lkp_ctx_i),
    .dmp_va_i    (dmp_va_i),
    .lkp_match_o (lkp_match),
    .dmp_match_o (dmp_match)
  );

  tlb_prio_enc #(.NUM_ENTRIES(NUM_ENTRIES)) u_prio (
    .req_i   (lkp_match),
    .found_o (found),
    .idx_o   (found_idx)
  );

  // demap wins over a concurrent lookup
  assign lkp_hit_o   = lkp_valid_i && !dmp_valid_i && found;
  assign lkp_idx_o   = lkp_hit_o ? found_idx : '0;
  assign hit_tte     = tte_q[found_idx];
  assign lkp_tte_o   = lkp_hit_o ? hit_tte : '0;
  assign lkp_read_o  = lkp_hit_o && !lkp_is_instr_i;
  assign lkp_write_o = lkp_hit_o && !lkp_is_instr_i && hit_tte[WRITE_BIT];
  assign lkp_exec_o  = lkp_hit_o && lkp_is_instr_i;

  assign kill     = dmp_valid_i ? dmp_match : '0;
  assign used_set = lkp_hit_o ? ({{(NUM_ENTRIES-1){1'b0}}, 1'b1} << found_idx) : '0;
  assign wr_idx   = wr_addr_i;

  tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_valid_i),
    .wr_idx_i   (wr_idx),
    .wr_tag_i   (wr_tag_i),
    .wr_tte_i   (wr_tte_i),
    .kill_i     (kill),
    .used_set_i (used_set),
    .tag_o      (tag_q),
    .tte_o      (tte_q)
  );
endmodule

// File: rtl/tlb_vpage_chk.sv
module tlb_vpage_chk
  import tlb_vpage_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              lkp_valid_i,
  input logic [CTX_W-1:0]                  lkp_ctx_i,
  input logic                              lkp_is_instr_i,
  input logic                              lkp_hit_o,
  input logic [IDX_W-1:0]                  lkp_idx_o,
  input logic [TTE_W-1:0]                  lkp_tte_o,
  input logic                              lkp_read_o,
  input logic                              lkp_write_o,
  input logic                              lkp_exec_o,
  input logic                              dmp_valid_i,
  input logic                              wr_valid_i,
  input logic [IDX_W-1:0]                  wr_idx_i,
  input logic [VA_W-1:0]                   wr_tag_i,
  input logic [TTE_W-1:0]                  wr_tte_i,
  input logic [NUM_ENTRIES-1:0][VA_W-1:0]  tag_q,
  input logic [NUM_ENTRIES-1:0][TTE_W-1:0] tte_q
);
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> !lkp_read_o && !lkp_write_o && !lkp_exec_o && lkp_tte_o == '0); // R7

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_valid_i); // R2

  AST_HIT_ENTRY_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> tte_q[lkp_idx_o][VALID_BIT] && tag_q[lkp_idx_o][CTX_W-1:0] == lkp_ctx_i); // R2

  AST_DATA_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o && !lkp_is_instr_i |-> lkp_read_o && !lkp_exec_o && lkp_write_o == lkp_tte_o[WRITE_BIT]); // R4

  AST_INSTR_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o && lkp_is_instr_i |-> lkp_exec_o && !lkp_read_o && !lkp_write_o); // R5

  AST_USED_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o && !(wr_valid_i && wr_idx_i == lkp_idx_o) |=> tte_q[$past(lkp_idx_o)][USED_BIT]); // R6

  AST_DEMAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmp_valid_i |-> !lkp_hit_o); // R10

  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> tte_q[$past(wr_idx_i)] == $past(wr_tte_i) && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)); // R11
endmodule

bind tlb_vpage tlb_vpage_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lkp_valid_i    (lkp_valid_i),
  .lkp_ctx_i      (lkp_ctx_i),
  .lkp_is_instr_i (lkp_is_instr_i),
  .lkp_hit_o      (lkp_hit_o),
  .lkp_idx_o      (lkp_idx_o),
  .lkp_tte_o      (lkp_tte_o),
  .lkp_read_o     (lkp_read_o),
  .lkp_write_o    (lkp_write_o),
  .lkp_exec_o     (lkp_exec_o),
  .dmp_valid_i    (dmp_valid_i),
  .wr_valid_i     (wr_valid_i),
  .wr_idx_i       (wr_idx),
  .wr_tag_i       (wr_tag_i),
  .wr_tte_i       (wr_tte_i),
  .tag_q          (tag_q),
  .tte_q          (tte_q)
);

// File: tb/tlb_vpage_bench.sv
module tlb_vpage_bench;
  localparam int N = 64;
  localparam logic [63:0] VBIT = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        lkp_valid, lkp_is_instr, dmp_valid, wr_valid;
  logic [63:0] lkp_va, dmp_va, wr_tag, wr_tte, lkp_tte;
  logic [12:0] lkp_ctx;
  logic [8:3]  wr_addr;
  logic        lkp_hit, lkp_read, lkp_write, lkp_exec;
  logic [5:0]  lkp_idx;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  tlb_vpage u_tlb_vpage (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid), .lkp_va_i(lkp_va), .lkp_ctx_i(lkp_ctx),
    .lkp_is_instr_i(lkp_is_instr), .lkp_hit_o(lkp_hit), .lkp_idx_o(lkp_idx),
    .lkp_tte_o(lkp_tte), .lkp_read_o(lkp_read), .lkp_write_o(lkp_write),
    .lkp_exec_o(lkp_exec), .dmp_valid_i(dmp_valid), .dmp_va_i(dmp_va),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_tag_i(wr_tag), .wr_tte_i(wr_tte)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] va_of(input int i);  return 64'(i + 1) << 32; endfunction
  function automatic logic [1:0]  sz_of(input int i);  return 2'(i % 4); endfunction
  function automatic logic [12:0] ctx_of(input int i); return 13'(i * 37 + 5); endfunction
  function automatic logic [63:0] psz_of(input int i); return 64'h2000 << (3 * int'(sz_of(i))); endfunction
  function automatic logic [63:0] tte_of(input int i);
    return VBIT | (64'(sz_of(i)) << 61) | (64'(i & 1) << 1) | (64'(i) << 13);
  endfunction

  task automatic idle();
    lkp_valid = 0; dmp_valid = 0; wr_valid = 0;
  endtask

  // each operation starts at a falling edge and holds through the next rising edge
  task automatic op_write(input int idx, input logic [63:0] tag, input logic [63:0] tte, input bit with_dmp);
    @(negedge clk); idle();
    wr_valid = 1; wr_addr = 6'(idx); wr_tag = tag; wr_tte = tte;
    dmp_valid = with_dmp; dmp_va = tag;
    #1;
  endtask

  task automatic op_lookup(input logic [63:0] va, input logic [12:0] ctx, input bit instr, input bit with_dmp);
    @(negedge clk); idle();
    lkp_valid = 1; lkp_va = va; lkp_ctx = ctx; lkp_is_instr = instr;
    dmp_valid = with_dmp; dmp_va = 64'hdead_0000_0000_0000;
    #1;
  endtask

  task automatic op_demap(input logic [63:0] va);
    @(negedge clk); idle();
    dmp_valid = 1; dmp_va = va;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 0; idle();
    lkp_va = '0; lkp_ctx = '0; lkp_is_instr = 0; dmp_va = '0;
    wr_addr = '0; wr_tag = '0; wr_tte = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset state misses, even on the all-zero tag
    op_lookup(64'h0, 13'h0, 0, 0);
    chk("R1 reset miss", 64'(lkp_hit), 0);

    for (int i = 0; i < N; i++) op_write(i, va_of(i) | 64'(ctx_of(i)), tte_of(i), 0);

    for (int i = 0; i < N; i++) begin
      op_lookup(va_of(i) + psz_of(i) - 1, ctx_of(i) + 13'd1, 0, 0);
      chk("R2 wrong context miss", 64'(lkp_hit), 0);
      chk("R7 miss word zero", lkp_tte, 0);
      op_lookup(va_of(i) + psz_of(i), ctx_of(i), 0, 0);
      chk("R3 past page miss", 64'(lkp_hit), 0);
      chk("R7 miss no perm", 64'({lkp_read, lkp_write, lkp_exec}), 0);
      op_lookup(va_of(i) + psz_of(i) - 1, ctx_of(i), 0, 0);
      chk("R3 last byte hit", 64'(lkp_hit), 1);
      chk("R2 hit slot", 64'(lkp_idx), 64'(i));
      chk("R7 R6 used clear before hit", lkp_tte, tte_of(i));
      chk("R4 data perms", 64'({lkp_read, lkp_write, lkp_exec}), 64'({1'b1, 1'(i & 1), 1'b0}));
      op_lookup(va_of(i), ctx_of(i), 1, 0);
      chk("R5 instr perms", 64'({lkp_hit, lkp_read, lkp_write, lkp_exec}), 64'(4'b1001));
      chk("R6 used set", 64'(lkp_tte[41]), 1);
    end

    // R8: duplicate mapping in slots 5 and 40
    op_write(40, 64'h7700_0000_0000 | 64'd1, VBIT, 0);
    op_write(5,  64'h7700_0000_0000 | 64'd1, VBIT, 0);
    op_lookup(64'h7700_0000_0010, 13'd1, 0, 0);
    chk("R8 lowest slot", 64'({lkp_hit, lkp_idx}), 64'({1'b1, 6'd5}));
    // R9: one demap removes both copies
    op_demap(64'h7700_0000_1000);
    op_lookup(64'h7700_0000_0010, 13'd1, 0, 0);
    chk("R9 all copies removed", 64'(lkp_hit), 0);
    // R9: 4 MB entry covered, 512 KB entry not covered
    op_demap(va_of(3) + 64'h30_0000);
    op_lookup(va_of(3) + 64'h10, ctx_of(3), 0, 0);
    chk("R9 large page demapped", 64'(lkp_hit), 0);
    op_demap(va_of(2) + 64'h8_0000);
    op_lookup(va_of(2), ctx_of(2), 0, 0);
    chk("R9 outside page kept", 64'({lkp_hit, lkp_idx}), 64'({1'b1, 6'd2}));

    // R10: demap in same cycle blocks hit and used marking
    op_write(6, va_of(6) | 64'(ctx_of(6)), tte_of(6), 0);
    op_lookup(va_of(6), ctx_of(6), 0, 1);
    chk("R10 demap blocks hit", 64'(lkp_hit), 0);
    op_lookup(va_of(6), ctx_of(6), 0, 0);
    chk("R10 used unchanged", lkp_tte, tte_of(6));
    chk("R11 rewrite clears used", 64'(lkp_idx), 6);

    // R12: write and covering demap together
    op_write(7, 64'h5500_0000_0000 | 64'd9, VBIT | 64'h2, 1);
    op_lookup(64'h5500_0000_0100, 13'd9, 0, 0);
    chk("R12 write survives demap", 64'({lkp_hit, lkp_idx, lkp_write}), 64'({1'b1, 6'd7, 1'b1}));

    // R1: reset again wipes a live entry
    @(negedge clk); idle(); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    op_lookup(va_of(10), ctx_of(10), 0, 0);
    chk("R1 reset clears", 64'(lkp_hit), 0);

    @(negedge clk); idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule